// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block is the host-side master for a 12-bit successive-approximation converter. The converter has a conversion-start strobe that is active low, a busy flag, and a serial data output. The sequencer starts each conversion and waits until the busy flag goes low. It then clocks out a 16-clock frame and delivers the low 12 bits of the frame as one result word on a valid/ready output. Before the next start strobe it inserts a quiet gap, so no read can overlap a start edge.

Two conversion styles are supported. In throughput style the strobe is a short low pulse and is back high long before the conversion ends. In sleep style the strobe stays low after each conversion so the converter powers down. At the next launch the strobe is raised to wake the converter and dropped again after a programmable wake interval, which starts the conversion. A start pulse runs one conversion. With the continuous input set, launches repeat at a fixed period. If the busy flag never falls, a timeout flag is raised.

The result port applies back-pressure. `res_valid` and `res_data` stay fixed until `res_ready` is seen high. The sequencer launches no conversion while a result is still waiting, so a result is never overwritten. A start pulse that arrives while a result is waiting is dropped. The sample period is then stretched by the time the consumer takes.

Top module: `sadc_host`

## Requirements
- R1: After reset, `adc_cnv_n` and `adc_sclk` are high, and `res_valid` and `conv_err` are low.
- R2: A throughput-style conversion drives `adc_cnv_n` low for exactly CONV_LOW_CYC clock cycles. The strobe is high again when the busy flag falls.
- R3: A sleep-style conversion keeps `adc_cnv_n` low through the end of conversion and afterwards while idle. A later sleep-style launch raises it for exactly WAKE_CYC cycles and then drives it low.
- R4: `adc_sclk` idles high and never goes low while the converter reports busy. A read starts only after the synchronised busy flag has fallen. A read is exactly 16 low pulses, each CLK_DIV cycles low and CLK_DIV cycles high.
- R5: `adc_sdata` is captured at each falling edge of `adc_sclk`, most significant bit first. `res_data` equals frame bits 11 down to 0, and the first four bits of the frame are discarded.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold. No conversion is launched while `res_valid` is high.
- R7: There is never a falling edge on `adc_cnv_n` during a read. There are at least GUARD_CYC cycles between the last rising `adc_sclk` edge of a read and the next falling `adc_cnv_n` edge.
- R8: With `cont_en` high and no back-pressure, successive launches are exactly PERIOD_CYC cycles apart. A launch is the falling strobe edge in throughput style. Once `cont_en` is low, the sequencer returns to idle after the current read and launches nothing further.
- R9: `start` is acted on only while the sequencer is idle with no result waiting. Each accepted start causes exactly one conversion.
- R10: If the busy flag does not fall within BUSY_TMO_CYC cycles after the sequencer starts waiting for it, `conv_err` goes high, no result is produced, and the sequencer returns to idle. `conv_err` clears at the next accepted start.
- R11: `sleep_mode` is sampled only when a start is accepted. Changing it during a conversion does not change that conversion's strobe levels. A throughput launch that follows a sleep-style conversion first raises the strobe for WAKE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to launch a conversion |
| cont_en | input | 1 | Repeat conversions at PERIOD_CYC while high |
| sleep_mode | input | 1 | 1 selects sleep style, 0 throughput style |
| res_ready | input | 1 | Consumer accepts the result word |
| adc_busy | input | 1 | Converter busy flag (asynchronous) |
| adc_sdata | input | 1 | Converter serial data |
| adc_cnv_n | output | 1 | Conversion-start strobe, active low |
| adc_sclk | output | 1 | Serial clock, idle high |
| res_valid | output | 1 | Result word is present |
| res_data | output | RES_BITS | Result word |
| conv_err | output | 1 | Busy timeout occurred |

## Verification
The bench builds the sequencer with CLK_DIV=2, CONV_LOW_CYC=5, WAKE_CYC=20, BUSY_TMO_CYC=200, GUARD_CYC=38 and PERIOD_CYC=400, and uses a converter model whose busy time is 60 cycles. With these values a frame takes 64 cycles, and both the timeout and the continuous period occur within a few hundred cycles. That makes the exact period spacing, the timeout return, the wake interval and the sleep-to-throughput switch reachable in a short run. Strobe widths, SCLK phase widths and the guard gap are measured on every conversion against the parameter values, not against fixed numbers.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV_PULSE,
    ST_WAIT_BUSY,
    ST_READ,
    ST_GUARD,
    ST_WAKE
  } ctl_state_e;
endpackage

// File: rtl/sadc_downcnt.sv
module sadc_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int DIV   = 5,
  parameter int NBITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tick,
  output logic last_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] nrise_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap      = run && (cnt_q == CNT_LAST);
  assign fall_tick = wrap && sclk_q;
  assign last_tick = wrap && !sclk_q && (nrise_q == BIT_LAST);
  assign sclk      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b1;
      nrise_q <= '0;
    end else if (!run) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b1;
      nrise_q <= '0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
      if (!sclk_q) nrise_q <= nrise_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_shift_in.sv
module sadc_shift_in #(
  parameter int KEEP = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            sdata,
  output logic [KEEP-1:0] word
);
  logic [KEEP-1:0] sh_q;

  generate
    if (KEEP > 1) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[KEEP-2:0], sdata};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= sdata;
      end
    end
  endgenerate

  assign word = sh_q;
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int CLK_DIV      = 5,
  parameter int FRAME_BITS   = 16,
  parameter int RES_BITS     = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int CONV_LOW_CYC = 6,
  parameter int WAKE_CYC     = 700,
  parameter int BUSY_TMO_CYC = 1000,
  parameter int GUARD_CYC    = 40,
  parameter int PERIOD_CYC   = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cont_en,
  input  logic                sleep_mode,
  input  logic                res_ready,
  input  logic                adc_busy,
  input  logic                adc_sdata,
  output logic                adc_cnv_n,
  output logic                adc_sclk,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic                conv_err
);
  localparam int M1 = (CONV_LOW_CYC > WAKE_CYC) ? CONV_LOW_CYC : WAKE_CYC;
  localparam int M2 = (BUSY_TMO_CYC > GUARD_CYC) ? BUSY_TMO_CYC : GUARD_CYC;
  localparam int TMR_MAX = (M1 > M2) ? M1 : M2;
  localparam int TW = $clog2(TMR_MAX + 1);
  localparam int PW = $clog2(PERIOD_CYC + 1);
  localparam logic [TW-1:0] LD_LOW   = TW'(CONV_LOW_CYC - 1);
  localparam logic [TW-1:0] LD_WAKE  = TW'(WAKE_CYC - 1);
  localparam logic [TW-1:0] LD_TMO   = TW'(BUSY_TMO_CYC - 1);
  localparam logic [TW-1:0] LD_GUARD = TW'(GUARD_CYC - 1);
  localparam logic [PW-1:0] LD_PER   = PW'(PERIOD_CYC - 1);

  ctl_state_e state, nxt;
  logic mode_q, mode_nxt;
  logic cnv_q, cnv_d;
  logic err_q, err_set, err_clr;
  logic tmr_load, tmr_zero, per_load, per_zero;
  logic [TW-1:0] tmr_val;
  logic [SYNC_STAGES-1:0] busy_sync;
  logic busy_fall;
  logic fall_tick, last_tick;
  logic [RES_BITS-1:0] word;
  logic vld_q;
  logic [RES_BITS-1:0] data_q;

  // busy crosses from the converter: synchronise, then find its falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_sync <= '0;
    else        busy_sync <= {busy_sync[SYNC_STAGES-2:0], adc_busy};
  end
  assign busy_fall = busy_sync[SYNC_STAGES-1] && !busy_sync[SYNC_STAGES-2];

  sadc_downcnt #(.W(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sadc_downcnt #(.W(PW)) per_i (
    .clk(clk), .rst_n(rst_n), .load(per_load), .load_val(LD_PER), .zero(per_zero)
  );

  sadc_sclk_gen #(.DIV(CLK_DIV), .NBITS(FRAME_BITS)) sclk_i (
    .clk(clk), .rst_n(rst_n), .run(state == ST_READ),
    .sclk(adc_sclk), .fall_tick(fall_tick), .last_tick(last_tick)
  );

  sadc_shift_in #(.KEEP(RES_BITS)) shin_i (
    .clk(clk), .rst_n(rst_n), .shift_en(fall_tick), .sdata(adc_sdata), .word(word)
  );

  always_comb begin
    nxt      = state;
    mode_nxt = mode_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    per_load = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && !vld_q) begin
          err_clr  = 1'b1;
          per_load = 1'b1;
          tmr_load = 1'b1;
          mode_nxt = sleep_mode;
          if (sleep_mode || mode_q) begin
            nxt     = ST_WAKE;
            tmr_val = LD_WAKE;
          end else begin
            nxt     = ST_CONV_PULSE;
            tmr_val = LD_LOW;
          end
        end
      end
      ST_WAKE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (mode_q) begin
            nxt     = ST_WAIT_BUSY;
            tmr_val = LD_TMO;
          end else begin
            nxt     = ST_CONV_PULSE;
            tmr_val = LD_LOW;
          end
        end
      end
      ST_CONV_PULSE: begin
        if (tmr_zero) begin
          nxt      = ST_WAIT_BUSY;
          tmr_load = 1'b1;
          tmr_val  = LD_TMO;
        end
      end
      ST_WAIT_BUSY: begin
        if (busy_fall) begin
          nxt = ST_READ;
        end else if (tmr_zero) begin
          nxt     = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_READ: begin
        if (last_tick) begin
          nxt      = ST_GUARD;
          tmr_load = 1'b1;
          tmr_val  = LD_GUARD;
        end
      end
      ST_GUARD: begin
        if (tmr_zero) begin
          if (!cont_en) begin
            nxt = ST_IDLE;
          end else if (per_zero && !vld_q) begin
            per_load = 1'b1;
            tmr_load = 1'b1;
            if (mode_q) begin
              nxt     = ST_WAKE;
              tmr_val = LD_WAKE;
            end else begin
              nxt     = ST_CONV_PULSE;
              tmr_val = LD_LOW;
            end
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // strobe level follows the next state: high while waking, low in the
  // start pulse, otherwise the resting level of the selected style
  assign cnv_d = (nxt == ST_WAKE) || (!mode_nxt && (nxt != ST_CONV_PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      cnv_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      state  <= nxt;
      mode_q <= mode_nxt;
      cnv_q  <= cnv_d;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (state == ST_READ && last_tick) begin
      vld_q  <= 1'b1;
      data_q <= word;
    end else if (vld_q && res_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign adc_cnv_n = cnv_q;
  assign res_valid = vld_q;
  assign res_data  = data_q;
  assign conv_err  = err_q;
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input ctl_state_e          state,
  input logic                mode_q,
  input logic                adc_cnv_n,
  input logic                adc_sclk,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data,
  input logic                conv_err
);
  // R6
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R6
  no_launch_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_CONV_PULSE || state == ST_WAKE) &&
     ($past(state) == ST_IDLE || $past(state) == ST_GUARD)) |-> !$past(res_valid));

  // R4
  sclk_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_sclk |-> state == ST_READ);

  // R7
  no_straddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cnv_n) |-> ($past(state) != ST_READ) && adc_sclk);

  // R2
  fast_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_BUSY && !mode_q) |-> adc_cnv_n);

  // R3
  sleep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT_BUSY || state == ST_READ || state == ST_GUARD) && mode_q) |-> !adc_cnv_n);

  // R10
  err_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_err) |-> ($past(state) == ST_WAIT_BUSY) && (state == ST_IDLE));
endmodule

bind sadc_host sadc_host_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .mode_q(mode_q),
  .adc_cnv_n(adc_cnv_n), .adc_sclk(adc_sclk), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .conv_err(conv_err)
);

// File: tb/sadc_host_tb_top.sv
`timescale 1ns/1ps
module sadc_host_tb_top;
  localparam int TB_DIV = 2;
  localparam int TB_LOW = 5;
  localparam int TB_WAKE = 20;
  localparam int TB_TMO = 200;
  localparam int TB_GUARD = 38;
  localparam int TB_PER = 400;
  localparam int ADC_CONV = 60;
  localparam int NVEC = 7;
  // {sleep style, 16-bit frame presented by the converter}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'hA5C3}, {1'b0, 16'h0FFF}, {1'b0, 16'hF000},
    {1'b1, 16'h1234}, {1'b1, 16'hFFFF}, {1'b0, 16'h8001}, {1'b0, 16'h7ABC}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cont_en = 1'b0, sleep_mode = 1'b0, res_ready = 1'b0;
  logic adc_busy = 1'b0, adc_sdata = 1'b0;
  logic adc_cnv_n, adc_sclk, res_valid, conv_err;
  logic [11:0] res_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  sadc_host #(
    .CLK_DIV(TB_DIV), .CONV_LOW_CYC(TB_LOW), .WAKE_CYC(TB_WAKE),
    .BUSY_TMO_CYC(TB_TMO), .GUARD_CYC(TB_GUARD), .PERIOD_CYC(TB_PER)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_en(cont_en),
    .sleep_mode(sleep_mode), .res_ready(res_ready), .adc_busy(adc_busy),
    .adc_sdata(adc_sdata), .adc_cnv_n(adc_cnv_n), .adc_sclk(adc_sclk),
    .res_valid(res_valid), .res_data(res_data), .conv_err(conv_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // converter model: conversion begins at a falling strobe edge
  bit dead = 1'b0;
  logic [15:0] adc_word = 16'h0;
  int mc = 0, bi = 0;
  logic m_pc = 1'b1, m_ps = 1'b1;
  always @(posedge clk) begin
    #1;
    if (m_pc && !adc_cnv_n && !dead) begin
      adc_busy = 1'b1;
      mc = ADC_CONV;
    end else if (adc_busy) begin
      mc--;
      if (mc == 0) begin
        adc_busy = 1'b0;
        bi = 15;
        adc_sdata = adc_word[15];
      end
    end
    if (!m_ps && adc_sclk && bi > 0) begin
      bi--;
      adc_sdata = adc_word[bi];
    end
    m_pc = adc_cnv_n;
    m_ps = adc_sclk;
  end

  // timing monitor
  bit exp_sleep = 1'b0;
  int n_cnv_fall = 0, n_sclk_fall = 0, fr_cnt = 0;
  int fall_at = 0, rise_at = 0, low_at = 0, last_rise = 0, last_fall_cyc = 0;
  bit fall_sleep = 1'b1, fall_seen = 1'b0, rise_sleep = 1'b0, rise_seen = 1'b0;
  bit in_frame = 1'b0, have_read = 1'b0;
  logic p_cnv = 1'b1, p_sclk = 1'b1, p_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (p_cnv && !adc_cnv_n) begin
        n_cnv_fall++;
        last_fall_cyc = cyc;
        chk(!in_frame, "R7 strobe fell inside read", in_frame, 0);
        if (have_read) chk(cyc - last_rise >= TB_GUARD, "R7 guard gap", cyc - last_rise, TB_GUARD);
        if (rise_seen && rise_sleep && exp_sleep) chk(cyc - rise_at == TB_WAKE, "R3 wake width", cyc - rise_at, TB_WAKE);
        fall_at = cyc; fall_sleep = exp_sleep; fall_seen = 1'b1;
      end
      if (!p_cnv && adc_cnv_n) begin
        if (fall_seen && !fall_sleep) chk(cyc - fall_at == TB_LOW, "R2 strobe low width", cyc - fall_at, TB_LOW);
        rise_at = cyc; rise_sleep = exp_sleep; rise_seen = 1'b1;
      end
      if (p_sclk && !adc_sclk) begin
        n_sclk_fall++;
        fr_cnt++;
        in_frame = 1'b1;
        low_at = cyc;
        chk(!adc_busy, "R4 sclk during conversion", adc_busy, 0);
      end
      if (!p_sclk && adc_sclk) begin
        chk(cyc - low_at == TB_DIV, "R4 sclk low width", cyc - low_at, TB_DIV);
        if (fr_cnt == 16) begin
          in_frame = 1'b0; fr_cnt = 0; last_rise = cyc; have_read = 1'b1;
        end
      end
      if (p_busy && !adc_busy)
        chk(adc_cnv_n == !exp_sleep, exp_sleep ? "R3 strobe low at end" : "R2 strobe high at end",
            adc_cnv_n, !exp_sleep);
    end
    p_cnv = adc_cnv_n; p_sclk = adc_sclk; p_busy = adc_busy;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      ok = res_valid;
    end
  endtask

  task automatic take_result();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
    chk(res_valid == 1'b0, "R6 valid drops after ready", res_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    int f0, s0, t0;
    int lc[4];
    logic [11:0] held;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(adc_cnv_n == 1'b1, "R1 strobe after reset", adc_cnv_n, 1);
    chk(adc_sclk == 1'b1, "R1 sclk after reset", adc_sclk, 1);
    chk(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
    chk(conv_err == 1'b0, "R1 error after reset", conv_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector walk: single conversions in both styles
    for (int v = 0; v < NVEC; v++) begin
      exp_sleep = VEC[v][16];
      sleep_mode = VEC[v][16];
      adc_word = VEC[v][15:0];
      f0 = n_cnv_fall; s0 = n_sclk_fall;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();  // R9: ignored, a conversion is running
      wait_valid(ok);
      chk(ok, "R5 result produced", ok, 1);
      chk(res_data == VEC[v][11:0], "R5 result word", res_data, VEC[v][11:0]);
      chk(n_sclk_fall - s0 == 16, "R4 sixteen sclk pulses", n_sclk_fall - s0, 16);
      take_result();
      repeat (TB_GUARD + 10) @(negedge clk);
      chk(n_cnv_fall - f0 == 1, "R9 one conversion per start", n_cnv_fall - f0, 1);
      chk(adc_cnv_n == !VEC[v][16], "R3 idle strobe level", adc_cnv_n, !VEC[v][16]);
    end

    // R11: style changed mid-conversion has no effect on it
    exp_sleep = 1'b1; sleep_mode = 1'b1; adc_word = 16'h0D2E;
    pulse_start();
    @(negedge clk) sleep_mode = 1'b0;
    wait_valid(ok);
    chk(res_data == 12'hD2E, "R11 result in latched style", res_data, 12'hD2E);
    take_result();
    repeat (TB_GUARD + 10) @(negedge clk);
    chk(adc_cnv_n == 1'b0, "R11 sleep level kept", adc_cnv_n, 0);
    exp_sleep = 1'b0;

    // R6: back-pressure holds the result and blocks launches
    adc_word = 16'h3C5A;
    pulse_start();
    wait_valid(ok);
    held = res_data;
    f0 = n_cnv_fall;
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    chk(res_valid == 1'b1, "R6 valid held", res_valid, 1);
    chk(res_data == held && held == 12'hC5A, "R6 data held", res_data, 12'hC5A);
    chk(n_cnv_fall == f0, "R9 start ignored while result waits", n_cnv_fall - f0, 0);
    take_result();
    repeat (TB_GUARD) @(negedge clk);

    // R10: busy never falls
    dead = 1'b1;
    pulse_start();
    repeat (TB_TMO + TB_LOW + 40) @(negedge clk);
    chk(conv_err == 1'b1, "R10 error raised", conv_err, 1);
    chk(res_valid == 1'b0, "R10 no result", res_valid, 0);
    chk(adc_cnv_n == 1'b1, "R10 back to idle level", adc_cnv_n, 1);
    dead = 1'b0;
    adc_word = 16'h0123;
    pulse_start();
    repeat (3) @(negedge clk);
    chk(conv_err == 1'b0, "R10 error cleared on start", conv_err, 0);
    wait_valid(ok);
    chk(res_data == 12'h123, "R10 recovery result", res_data, 12'h123);
    take_result();
    repeat (TB_GUARD + 10) @(negedge clk);

    // R8: continuous launches at a fixed period
    res_ready = 1'b1; cont_en = 1'b1; adc_word = 16'h5555;
    f0 = n_cnv_fall;
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      t0 = 0;
      while (n_cnv_fall - f0 <= k && t0 < 2000) begin
        @(negedge clk); t0++;
      end
      lc[k] = last_fall_cyc;
    end
    for (int k = 1; k < 4; k++)
      chk(lc[k] - lc[k-1] == TB_PER, "R8 launch spacing", lc[k] - lc[k-1], TB_PER);
    cont_en = 1'b0;
    f0 = n_cnv_fall;
    repeat (3 * TB_PER) @(negedge clk);
    chk(n_cnv_fall == f0, "R8 stops after cont_en drops", n_cnv_fall - f0, 0);
    chk(res_data == 12'h555, "R8 continuous result", res_data, 12'h555);
    res_ready = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule